// File: doc/BRIEF.md
# LIN Master Frame Configuration Loader

This block sits between a byte-wide DMA write/read path and a LIN master's byte-level transmit and receive machinery. The DMA engine writes single bytes into a transmit holding port whenever the block asks for one. The DMA engine reads single bytes from a receive holding port whenever the block reports one ready. A sequencer turns this stream into a frame. The frame has a configuration, an identifier, and then either a run of data bytes to send or a run of received bytes to hand back.

A source-select input picks where the frame configuration comes from.

- **In-band source:** each frame opens with two configuration bytes. The first holds the flag byte and the second holds the data length code.
- **Register source:** the configuration is taken from a static register image driven on input pins. The configuration is captured when the identifier byte is written, which is the first byte of the frame.

Bit timing, break and sync generation, and checksum computation live downstream. The block hands the identifier and payload bytes to a one-entry transmit holding stage with a valid/ready handshake. It accepts received payload bytes through a ready/valid handshake into a one-entry receive holding register.

Top module: `lin_frame_loader`

## Requirements
- R1: A byte on the write port is taken only on a clock edge where `wr_req` is high. A write presented while `wr_req` is low has no effect: nothing is sent downstream and the frame sequence does not advance.
- R2: With `cfg_inband`=1, the first byte of a frame is decoded as follows. Bits 1:0 are the node action (00 publish, 01 subscribe, 10 or 11 ignore), bit 2 is parity-off, bit 3 is checksum-off, bit 4 is checksum kind, bit 5 is length mode, bit 6 is slot-off, and bit 7 is ignored. The second byte becomes the 8-bit data length code. The register inputs are ignored in this mode.
- R3: With `cfg_inband`=0, the first write of a frame is the identifier. The flag byte (same bit layout as R2) and the length code are captured from `reg_flags` and `reg_dlc` on that same edge.
- R4: The identifier is the first byte passed downstream in every frame. When parity-off is 0, bit 6 is replaced by id0^id1^id2^id4 and bit 7 by NOT(id1^id3^id4^id5). When parity-off is 1, the byte passes unchanged.
- R5: A frame carries min(length code + 1, 8) data bytes. After the last one, the block accepts no further data for that frame and waits for the next frame's first byte.
- R6: For publish, the data bytes written after the identifier are passed downstream in write order.
- R7: For subscribe, `ds_rx_ready` is high only during the data phase while the receive holding register is empty. Each accepted byte appears on `rd_data` with `rx_ready` high until a `rd_ack` pulse empties the register. Bytes come out in arrival order.
- R8: For ignore, no data phase occurs. `ds_rx_ready` and `rx_ready` stay low for the whole frame, and the next write starts a new frame.
- R9: Once `ds_tx_valid` is high, it stays high with `ds_tx_data` unchanged until a cycle where `ds_tx_ready` is high.
- R10: `wr_req` is high during both in-band configuration byte slots. It is high during the identifier and publish data slots only while the transmit holding stage is empty. It is low throughout the subscribe data phase.
- R11: After reset, the decoded configuration outputs are zero, `ds_tx_valid`, `rx_ready` and `ds_rx_ready` are low, and the block waits for the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inband | input | 1 | 1: configuration arrives in the byte stream; 0: from register inputs |
| reg_flags | input | 8 | Register image of the flag byte (bit layout as R2) |
| reg_dlc | input | 8 | Register image of the data length code |
| wr_valid | input | 1 | Write byte present on the transmit holding port |
| wr_data | input | 8 | Write byte |
| wr_req | output | 1 | Request for the next write byte |
| rd_ack | input | 1 | Read strobe that empties the receive holding register |
| rd_data | output | 8 | Receive holding register contents |
| rx_ready | output | 1 | Received byte available to read |
| ds_tx_valid | output | 1 | Downstream transmit byte valid |
| ds_tx_data | output | 8 | Downstream transmit byte |
| ds_tx_ready | input | 1 | Downstream takes the transmit byte |
| ds_rx_valid | input | 1 | Downstream offers a received byte |
| ds_rx_data | input | 8 | Received byte |
| ds_rx_ready | output | 1 | Block accepts the received byte |
| frm_nact | output | 2 | Current frame node action |
| frm_par_off | output | 1 | Current frame parity-off flag |
| frm_chk_off | output | 1 | Current frame checksum-off flag |
| frm_chk_kind | output | 1 | Current frame checksum kind |
| frm_len_mode | output | 1 | Current frame length mode |
| frm_slot_off | output | 1 | Current frame slot-off flag |
| frm_dlc | output | 8 | Current frame data length code |

## Verification
The embedded properties watch, on every cycle, several invariants:
- the downstream byte is held while stalled;
- the transmit stage is never overwritten;
- the receive register never overruns;
- the remaining-byte count stays within its cap and is nonzero in a data phase;
- the frame configuration is frozen during a data phase.

The bench's scenarios cover what no single-cycle property can capture:
- the field decoding in both configuration sources;
- the identifier parity values;
- the exact number and order of bytes per frame;
- writes being ignored while the block is not requesting;
- the silence of the receive side in ignore frames.

// File: rtl/lfl_pkg.sv
package lfl_pkg;

   typedef enum logic [2:0] {
      ST_START = 3'd0,
      ST_DLC   = 3'd1,
      ST_ID    = 3'd2,
      ST_TXD   = 3'd3,
      ST_RXD   = 3'd4
   } lfl_state_e;

   // Flag byte bits 6:0; first member is the most significant bit
   typedef struct packed {
      logic       slot_off;
      logic       len_mode;
      logic       chk_kind;
      logic       chk_off;
      logic       par_off;
      logic [1:0] nact;
   } lfl_flags_t;

   localparam logic [1:0] NACT_PUB = 2'b00;
   localparam logic [1:0] NACT_SUB = 2'b01;

   // LIN protected identifier: returns {P1, P0}
   function automatic logic [1:0] lfl_id_parity(input logic [5:0] id);
      logic p0;
      logic p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0};
   endfunction

endpackage

// File: rtl/lfl_tx_hold.sv
module lfl_tx_hold #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_data_i,
   output logic              full_o,
   output logic              ds_valid_o,
   output logic [BYTE_W-1:0] ds_data_o,
   input  logic              ds_ready_i
);

   logic              valid_q;
   logic [BYTE_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         data_q  <= load_data_i;
      end else if (ds_ready_i) begin
         valid_q <= 1'b0;
      end
   end

   assign full_o     = valid_q;
   assign ds_valid_o = valid_q;
   assign ds_data_o  = data_q;

   AST_TX_HELD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ds_ready_i) |=> (valid_q && $stable(data_q))); // R9
   AST_TX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !valid_q); // R10

endmodule

// File: rtl/lfl_rx_hold.sv
module lfl_rx_hold #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [BYTE_W-1:0] take_data_i,
   input  logic              rd_i,
   output logic              full_o,
   output logic [BYTE_W-1:0] rd_data_o
);

   logic              full_q;
   logic [BYTE_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take_i) begin
         full_q <= 1'b1;
         data_q <= take_data_i;
      end else if (rd_i) begin
         full_q <= 1'b0;
      end
   end

   assign full_o    = full_q;
   assign rd_data_o = data_q;

   AST_RX_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> !full_q); // R7
   AST_RX_KEPT_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !rd_i) |=> (full_q && $stable(data_q))); // R7

endmodule

// File: rtl/lfl_seq.sv
module lfl_seq
   import lfl_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MAX_DATA  = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_inband_i,
   input  logic [BYTE_W-1:0] reg_flags_i,
   input  logic [BYTE_W-1:0] reg_dlc_i,
   input  logic              wr_valid_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic              wr_req_o,
   input  logic              tx_full_i,
   output logic              tx_load_o,
   output logic [BYTE_W-1:0] tx_load_data_o,
   input  logic              rx_take_i,
   output logic              rx_open_o,
   output lfl_flags_t        flags_o,
   output logic [BYTE_W-1:0] dlc_o
);

   localparam int CNT_W = $clog2(MAX_DATA + 1);
   localparam logic [BYTE_W-1:0] LAST_DLC  = BYTE_W'(MAX_DATA - 1);
   localparam logic [CNT_W-1:0]  BEATS_MAX = CNT_W'(MAX_DATA);

   lfl_state_e        st_q;
   lfl_flags_t        flags_q;
   logic [BYTE_W-1:0] dlc_q;
   logic [CNT_W-1:0]  cnt_q;

   logic              start_reg;
   lfl_flags_t        flags_src;
   logic [BYTE_W-1:0] dlc_src;
   logic [CNT_W-1:0]  beats;
   logic              wr_take;
   logic              id_take;
   logic              data_take;
   logic [BYTE_W-1:0] id_out;
   lfl_state_e        st_after_id;

   // Register source: first byte of the frame is the identifier
   assign start_reg = (st_q == ST_START) && !cfg_inband_i;
   assign flags_src = start_reg ? lfl_flags_t'(reg_flags_i[6:0]) : flags_q;
   assign dlc_src   = start_reg ? reg_dlc_i : dlc_q;
   assign beats     = (dlc_src >= LAST_DLC) ? BEATS_MAX
                                            : (CNT_W'(dlc_src) + CNT_W'(1));

   always_comb begin
      unique case (st_q)
         ST_START: wr_req_o = cfg_inband_i ? 1'b1 : !tx_full_i;
         ST_DLC:   wr_req_o = 1'b1;
         ST_ID:    wr_req_o = !tx_full_i;
         ST_TXD:   wr_req_o = !tx_full_i;
         default:  wr_req_o = 1'b0;
      endcase
   end

   assign wr_take   = wr_valid_i && wr_req_o;
   assign id_take   = wr_take && ((st_q == ST_ID) || start_reg);
   assign data_take = wr_take && (st_q == ST_TXD);

   always_comb begin
      unique case (flags_src.nact)
         NACT_PUB: st_after_id = ST_TXD;
         NACT_SUB: st_after_id = ST_RXD;
         default:  st_after_id = ST_START;
      endcase
   end

   generate
      if (PARITY_EN) begin : g_parity
         assign id_out = flags_src.par_off ? wr_data_i
                                           : {lfl_id_parity(wr_data_i[5:0]), wr_data_i[5:0]};
      end else begin : g_no_parity
         assign id_out = wr_data_i;
      end
   endgenerate

   assign tx_load_o      = id_take || data_take;
   assign tx_load_data_o = id_take ? id_out : wr_data_i;
   assign rx_open_o      = (st_q == ST_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_START;
         flags_q <= '0;
         dlc_q   <= '0;
         cnt_q   <= '0;
      end else begin
         unique case (st_q)
            ST_START: if (wr_take) begin
               if (cfg_inband_i) begin
                  flags_q <= lfl_flags_t'(wr_data_i[6:0]);
                  st_q    <= ST_DLC;
               end else begin
                  flags_q <= flags_src;
                  dlc_q   <= reg_dlc_i;
                  cnt_q   <= beats;
                  st_q    <= st_after_id;
               end
            end
            ST_DLC: if (wr_take) begin
               dlc_q <= wr_data_i;
               st_q  <= ST_ID;
            end
            ST_ID: if (wr_take) begin
               cnt_q <= beats;
               st_q  <= st_after_id;
            end
            ST_TXD: if (data_take) begin
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) st_q <= ST_START;
            end
            ST_RXD: if (rx_take_i) begin
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) st_q <= ST_START;
            end
            default: st_q <= ST_START;
         endcase
      end
   end

   assign flags_o = flags_q;
   assign dlc_o   = dlc_q;

   AST_CNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= BEATS_MAX); // R5
   AST_CNT_LIVE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_TXD) || (st_q == ST_RXD)) |-> (cnt_q != '0)); // R5
   AST_CFG_FROZEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_TXD) || (st_q == ST_RXD)) |=> ($stable(flags_q) && $stable(dlc_q))); // R2
   AST_RX_ONLY_IN_SUBSCRIBE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take_i |-> (flags_q.nact == NACT_SUB)); // R8

endmodule

// File: rtl/lin_frame_loader.sv
module lin_frame_loader
   import lfl_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MAX_DATA  = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_inband,
   input  logic [BYTE_W-1:0] reg_flags,
   input  logic [BYTE_W-1:0] reg_dlc,
   input  logic              wr_valid,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              wr_req,
   input  logic              rd_ack,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rx_ready,
   output logic              ds_tx_valid,
   output logic [BYTE_W-1:0] ds_tx_data,
   input  logic              ds_tx_ready,
   input  logic              ds_rx_valid,
   input  logic [BYTE_W-1:0] ds_rx_data,
   output logic              ds_rx_ready,
   output logic [1:0]        frm_nact,
   output logic              frm_par_off,
   output logic              frm_chk_off,
   output logic              frm_chk_kind,
   output logic              frm_len_mode,
   output logic              frm_slot_off,
   output logic [BYTE_W-1:0] frm_dlc
);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("lin_frame_loader: transfers are single bytes, BYTE_W must be 8");
      end
      if (MAX_DATA < 1 || MAX_DATA > 255) begin : g_bad_depth
         $error("lin_frame_loader: MAX_DATA must lie in 1..255");
      end
   endgenerate

   logic              tx_full;
   logic              tx_load;
   logic [BYTE_W-1:0] tx_load_data;
   logic              rx_open;
   logic              rx_full;
   logic              rx_take;
   lfl_flags_t        flags;

   assign ds_rx_ready = rx_open && !rx_full;
   assign rx_take     = ds_rx_valid && ds_rx_ready;
   assign rx_ready    = rx_full;

   lfl_seq #(
      .BYTE_W    (BYTE_W),
      .MAX_DATA  (MAX_DATA),
      .PARITY_EN (PARITY_EN)
   ) seq_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_inband_i   (cfg_inband),
      .reg_flags_i    (reg_flags),
      .reg_dlc_i      (reg_dlc),
      .wr_valid_i     (wr_valid),
      .wr_data_i      (wr_data),
      .wr_req_o       (wr_req),
      .tx_full_i      (tx_full),
      .tx_load_o      (tx_load),
      .tx_load_data_o (tx_load_data),
      .rx_take_i      (rx_take),
      .rx_open_o      (rx_open),
      .flags_o        (flags),
      .dlc_o          (frm_dlc)
   );

   lfl_tx_hold #(.BYTE_W(BYTE_W)) tx_hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (tx_load),
      .load_data_i (tx_load_data),
      .full_o      (tx_full),
      .ds_valid_o  (ds_tx_valid),
      .ds_data_o   (ds_tx_data),
      .ds_ready_i  (ds_tx_ready)
   );

   lfl_rx_hold #(.BYTE_W(BYTE_W)) rx_hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (rx_take),
      .take_data_i (ds_rx_data),
      .rd_i        (rd_ack),
      .full_o      (rx_full),
      .rd_data_o   (rd_data)
   );

   assign frm_nact     = flags.nact;
   assign frm_par_off  = flags.par_off;
   assign frm_chk_off  = flags.chk_off;
   assign frm_chk_kind = flags.chk_kind;
   assign frm_len_mode = flags.len_mode;
   assign frm_slot_off = flags.slot_off;

   AST_RX_READY_NOT_IN_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      ds_rx_ready |-> !wr_req); // R10
   AST_WRITE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> wr_valid); // R1

endmodule

// File: tb/lin_frame_loader_tb_top.sv
`timescale 1ns/100ps
module lin_frame_loader_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_inband = 1'b1;
   logic [7:0] reg_flags = 8'h00;
   logic [7:0] reg_dlc = 8'h00;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_req;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data;
   logic       rx_ready;
   logic       ds_tx_valid;
   logic [7:0] ds_tx_data;
   logic       ds_tx_ready = 1'b1;
   logic       ds_rx_valid = 1'b0;
   logic [7:0] ds_rx_data = 8'h00;
   logic       ds_rx_ready;
   logic [1:0] frm_nact;
   logic       frm_par_off, frm_chk_off, frm_chk_kind, frm_len_mode, frm_slot_off;
   logic [7:0] frm_dlc;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit stall_en = 1'b0;
   bit watch_rx = 1'b0;
   int rx_leak = 0;
   bit prev_stall = 1'b0;
   logic [7:0] prev_data = 8'h00;
   logic [7:0] txq[$];

   always #2.5 clk = ~clk;

   lin_frame_loader dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_inband(cfg_inband),
      .reg_flags(reg_flags), .reg_dlc(reg_dlc),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_req(wr_req),
      .rd_ack(rd_ack), .rd_data(rd_data), .rx_ready(rx_ready),
      .ds_tx_valid(ds_tx_valid), .ds_tx_data(ds_tx_data), .ds_tx_ready(ds_tx_ready),
      .ds_rx_valid(ds_rx_valid), .ds_rx_data(ds_rx_data), .ds_rx_ready(ds_rx_ready),
      .frm_nact(frm_nact), .frm_par_off(frm_par_off), .frm_chk_off(frm_chk_off),
      .frm_chk_kind(frm_chk_kind), .frm_len_mode(frm_len_mode),
      .frm_slot_off(frm_slot_off), .frm_dlc(frm_dlc)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // Downstream stall pattern, changed just after each rising edge
   always @(posedge clk) begin
      #1;
      cyc++;
      ds_tx_ready = stall_en ? ((cyc % 3) == 0) : 1'b1;
   end

   // Transfer log and hold check (R9), sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(ds_tx_valid && (ds_tx_data == prev_data), "R9", "held byte",
                  {ds_tx_valid, ds_tx_data}, {1'b1, prev_data});
         if (ds_tx_valid && ds_tx_ready) txq.push_back(ds_tx_data);
         if (watch_rx && (rx_ready || ds_rx_ready)) rx_leak++;
         prev_stall = ds_tx_valid && !ds_tx_ready;
         prev_data  = ds_tx_data;
      end
   end

   function automatic logic [7:0] exp_id(input logic [7:0] r, input bit pd);
      logic p0, p1;
      p0 = r[0] ^ r[1] ^ r[2] ^ r[4];
      p1 = ~(r[1] ^ r[3] ^ r[4] ^ r[5]);
      return pd ? r : {p1, p0, r[5:0]};
   endfunction

   function automatic logic [7:0] dbyte(input int fi, input int k);
      return 8'((fi * 37 + k * 11 + 3) & 255);
   endfunction

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = b;
      while (!wr_req) @(negedge clk);
      @(posedge clk);
      #1;
      wr_valid = 1'b0;
   endtask

   task automatic run_frame(input int fi, input bit inband, input logic [1:0] nact,
                            input logic [7:0] dlc, input bit stall);
      logic [6:0] fl;
      logic [7:0] idr;
      int n;
      fl  = {fi[4], fi[3], fi[2], fi[1], fi[0], nact};
      idr = 8'((fi * 53 + 7) & 255);
      n   = (dlc >= 8'd7) ? 8 : int'(dlc) + 1;
      txq.delete();
      cfg_inband = inband;
      stall_en   = stall;
      if (inband) begin
         reg_flags = ~{1'b0, fl};
         reg_dlc   = ~dlc;
         put_byte({fi[5], fl});
         put_byte(dlc);
      end else begin
         reg_flags = {fi[5], fl};
         reg_dlc   = dlc;
      end
      if (nact == 2'b10) watch_rx = 1'b1;
      put_byte(idr);
      if (nact == 2'b00) begin
         for (int k = 0; k < n; k++) put_byte(dbyte(fi, k));
      end else if (nact == 2'b01) begin
         @(negedge clk);
         check(wr_req == 1'b0, "R10", "wr_req in subscribe data", wr_req, 0);
         wr_valid = 1'b1;                 // R1: write without request
         wr_data  = 8'hA5;
         @(posedge clk);
         #1;
         wr_valid = 1'b0;
         for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ds_rx_valid = 1'b1;
            ds_rx_data  = dbyte(fi, k) ^ 8'h5A;
            while (!ds_rx_ready) @(negedge clk);
            @(posedge clk);
            #1;
            ds_rx_valid = 1'b0;
            @(negedge clk);
            while (!rx_ready) @(negedge clk);
            check(ds_rx_ready == 1'b0, "R7", "ds_rx_ready while full", ds_rx_ready, 0);
            check(rd_data == (dbyte(fi, k) ^ 8'h5A), "R7", "rx byte order", rd_data,
                  dbyte(fi, k) ^ 8'h5A);
            rd_ack = 1'b1;
            @(posedge clk);
            #1;
            rd_ack = 1'b0;
            @(negedge clk);
            check(rx_ready == 1'b0, "R7", "rx_ready after read", rx_ready, 0);
         end
         repeat (2) @(negedge clk);
         check(ds_rx_ready == 1'b0, "R5", "no rx beyond length", ds_rx_ready, 0);
      end
      stall_en = 1'b0;
      repeat (5) @(negedge clk);
      if (nact == 2'b10) begin
         check(rx_leak == 0, "R8", "rx activity in ignore frame", rx_leak, 0);
         check(wr_req == 1'b1, "R8", "ready for next frame", wr_req, 1);
         watch_rx = 1'b0;
         rx_leak  = 0;
      end
      check(txq.size() == ((nact == 2'b00) ? n + 1 : 1),
            (nact == 2'b00) ? "R5" : "R1", "downstream byte count",
            txq.size(), (nact == 2'b00) ? n + 1 : 1);
      if (txq.size() > 0)
         check(txq[0] == exp_id(idr, fl[2]), "R4", "identifier byte", txq[0],
               exp_id(idr, fl[2]));
      if (nact == 2'b00) begin
         for (int k = 0; k < n; k++)
            if (k + 1 < txq.size())
               check(txq[k+1] == dbyte(fi, k), "R6", "publish byte order", txq[k+1],
                     dbyte(fi, k));
      end
      check({frm_slot_off, frm_len_mode, frm_chk_kind, frm_chk_off, frm_par_off, frm_nact} == fl,
            inband ? "R2" : "R3", "decoded flags",
            {frm_slot_off, frm_len_mode, frm_chk_kind, frm_chk_off, frm_par_off, frm_nact}, fl);
      check(frm_dlc == dlc, inband ? "R2" : "R3", "decoded length code", frm_dlc, dlc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "all", "watchdog timeout", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int fi;
      logic [7:0] dl [7];
      dl = '{8'd0, 8'd1, 8'd3, 8'd6, 8'd7, 8'd8, 8'd255};
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_req == 1'b1, "R11", "wr_req after reset", wr_req, 1);
      check(ds_tx_valid == 1'b0, "R11", "ds_tx_valid after reset", ds_tx_valid, 0);
      check(rx_ready == 1'b0 && ds_rx_ready == 1'b0, "R11", "rx side after reset",
            {rx_ready, ds_rx_ready}, 0);
      check(frm_dlc == 8'h00 && frm_nact == 2'b00, "R11", "config after reset",
            {frm_nact, frm_dlc}, 0);
      // R10: in-band config slot requested even while the hold is busy
      fi = 0;
      for (int m = 1; m >= 0; m--) begin
         for (int a = 0; a < 3; a++) begin
            for (int d = 0; d < 7; d++) begin
               run_frame(fi, m[0], 2'(a), dl[d], (fi % 4) == 1);
               fi++;
            end
         end
      end
      // Node action code 11 behaves as ignore (R8)
      run_frame(fi, 1'b1, 2'b11, 8'd4, 1'b0);
      summary();
      $finish;
   end

endmodule